// File: doc/BRIEF.md
# Frequency Tuning Word Router with Window Clamp

This block picks the 48-bit frequency tuning word that will drive a direct digital synthesizer's phase accumulator. Three candidate words arrive at its inputs: a free-running value held in a configuration register, the word produced by the digital loop filter, and a stored history word. A two-bit routing code chooses one of them, or freezes the present output.

The chosen word then passes through a window clamp with programmable lower and upper limits. The result is registered toward the synthesizer, and a one-cycle valid pulse marks each new word. Sticky flags record whether the clamp had to pull the word up to the lower limit or down to the upper limit. Each flag is cleared by a write-one-to-clear pulse. A separate level flag reports a window whose lower limit sits above its upper limit.

The routing is kept as a small state machine whose state is the route used at the last clock edge. There are four states: `RT_FREE` (code 00), `RT_LOOP` (code 01), `RT_HIST` (code 10) and `RT_HOLD` (code 11, the reset state). On every clock edge the machine takes the transition to the state named by the present routing code. A transition to a different state counts as a route change for the valid pulse; a self-transition does not.

Top module: `tw_route_clamp`

## Requirements
- R1: Routing code 2'b00 selects `free_word`, 2'b01 selects the loop filter word and 2'b10 selects `hist_word`. The clamped choice appears on `tw_out` after the next rising clock edge.
- R2: Routing code 2'b11 takes the current `tw_out` as the candidate, still subject to the clamp. Inside the window the output therefore stays frozen, whatever the other sources do.
- R3: While `loop_strobe` is high, `loop_word` is used directly and is also stored. While the strobe is low, the last stored word is used (0 after reset), and changes on `loop_word` have no effect.
- R4: Comparisons are unsigned. A candidate below `lim_lo` yields `lim_lo`, and a candidate above `lim_hi` yields `lim_hi`. A candidate equal to either limit passes unchanged.
- R5: When `lim_lo` > `lim_hi`, the output is always `lim_lo`. `cfg_err` is high after the next edge, and it returns low one edge after the window is valid again.
- R6: `clamp_lo_flag` is set after an edge at which the candidate was below `lim_lo`. It stays set until an edge with `clr_lo` high and no new low clamp; if both happen at the same edge, the set wins.
- R7: `clamp_hi_flag` is set after an edge at which the candidate was at or above `lim_lo` and above `lim_hi`. It is cleared by `clr_hi` with the same rules as R6.
- R8: `tw_valid` is high for the cycle after an edge at which either the routing code differed from the one taken at the previous edge, or the clamped word differed from the current `tw_out`. Otherwise it is low.
- R9: During and right after reset, `tw_out` is 0. `tw_valid`, both clamp flags and `cfg_err` are 0, and the remembered route is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| route_sel | input | 2 | Routing code (00 free, 01 loop, 10 history, 11 hold) |
| free_word | input | 48 | Free-running tuning word |
| loop_word | input | 48 | Loop filter tuning word |
| loop_strobe | input | 1 | Update strobe for the loop filter word |
| hist_word | input | 48 | History tuning word |
| lim_lo | input | 48 | Lower clamp limit |
| lim_hi | input | 48 | Upper clamp limit |
| clr_lo | input | 1 | Write-one-to-clear pulse for the low clamp flag |
| clr_hi | input | 1 | Write-one-to-clear pulse for the high clamp flag |
| tw_out | output | 48 | Registered tuning word toward the synthesizer |
| tw_valid | output | 1 | One-cycle pulse marking a new or re-routed word |
| clamp_lo_flag | output | 1 | Sticky low-clamp flag |
| clamp_hi_flag | output | 1 | Sticky high-clamp flag |
| cfg_err | output | 1 | Lower limit above upper limit |

## Verification
Directed words placed exactly on, one below and one above each limit show the strict unsigned compare. A word with its top bit set shows the compare is not signed. Switching through every routing code while the other sources keep moving separates real selection from hold. Toggling the loop word with the strobe low shows it is ignored. An inverted window shows that the lower limit takes priority, and a clear pulse landing on a new clamp shows that the set wins. A long random run then mixes routes, strobes, limit changes (some inverted) and clear pulses, so that valid pulses from route changes and from word changes are both seen, alone and together.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [1:0] {
        RT_FREE = 2'b00,
        RT_LOOP = 2'b01,
        RT_HIST = 2'b10,
        RT_HOLD = 2'b11
    } route_t;

    typedef struct packed {
        logic lo_hit;
        logic hi_hit;
        logic inverted;
    } clamp_stat_t;

    localparam int NFLAG  = 2;
    localparam int FLG_LO = 0;
    localparam int FLG_HI = 1;

endpackage

// File: rtl/tw_loop_hold.sv
module tw_loop_hold #(
    parameter int TW_W = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strobe,
    input  logic [TW_W-1:0] word_in,
    output logic [TW_W-1:0] word_eff
);

    logic [TW_W-1:0] held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (strobe) begin
            held_q <= word_in;
        end
    end

    assign word_eff = strobe ? word_in : held_q;

    // R3: without a strobe the stored loop word cannot move
    assert_loop_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> (held_q == $past(held_q)));

endmodule

// File: rtl/tw_window_clamp.sv
module tw_window_clamp
    import tw_pkg::*;
#(
    parameter int TW_W = 48
) (
    input  logic [TW_W-1:0] cand,
    input  logic [TW_W-1:0] lo,
    input  logic [TW_W-1:0] hi,
    output logic [TW_W-1:0] word_o,
    output clamp_stat_t     stat_o
);

    logic below;
    logic above;
    logic inv;

    always_comb begin
        below = (cand < lo);
        above = (cand > hi);
        inv   = (lo > hi);

        stat_o          = '0;
        stat_o.inverted = inv;
        word_o          = cand;

        if (below) begin
            word_o        = lo;
            stat_o.lo_hit = 1'b1;
        end else if (above) begin
            word_o        = inv ? lo : hi;
            stat_o.hi_hit = 1'b1;
        end
    end

endmodule

// File: rtl/tw_sticky_flag.sv
module tw_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else begin
            flag_o <= (flag_o & ~clr_i) | set_i;
        end
    end

    // R6 (also R7 through the second instance): a set flag survives without a clear
    assert_flag_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

    // R6: a set request always lands, even against a clear
    assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

endmodule

// File: rtl/tw_route_clamp.sv
module tw_route_clamp
    import tw_pkg::*;
#(
    parameter int TW_W = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      route_sel,
    input  logic [TW_W-1:0] free_word,
    input  logic [TW_W-1:0] loop_word,
    input  logic            loop_strobe,
    input  logic [TW_W-1:0] hist_word,
    input  logic [TW_W-1:0] lim_lo,
    input  logic [TW_W-1:0] lim_hi,
    input  logic            clr_lo,
    input  logic            clr_hi,
    output logic [TW_W-1:0] tw_out,
    output logic            tw_valid,
    output logic            clamp_lo_flag,
    output logic            clamp_hi_flag,
    output logic            cfg_err
);

    route_t          state_q;
    route_t          route_in;
    logic [TW_W-1:0] loop_eff;
    logic [TW_W-1:0] cand;
    logic [TW_W-1:0] clamped;
    clamp_stat_t     stat;
    logic [TW_W-1:0] tw_q;
    logic            valid_q;
    logic            cfg_q;
    logic            route_change;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_clr;
    logic [NFLAG-1:0] flag_q;

    assign route_in = route_t'(route_sel);

    tw_loop_hold #(.TW_W(TW_W)) u_loop (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (loop_strobe),
        .word_in  (loop_word),
        .word_eff (loop_eff)
    );

    // State register: the route taken at the last edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RT_HOLD;
        end else begin
            state_q <= route_in;
        end
    end

    // Output process: candidate selection and transition detection
    always_comb begin
        route_change = (route_in != state_q);
        unique case (route_in)
            RT_FREE: cand = free_word;
            RT_LOOP: cand = loop_eff;
            RT_HIST: cand = hist_word;
            RT_HOLD: cand = tw_q;
        endcase
    end

    tw_window_clamp #(.TW_W(TW_W)) u_clamp (
        .cand   (cand),
        .lo     (lim_lo),
        .hi     (lim_hi),
        .word_o (clamped),
        .stat_o (stat)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tw_q    <= '0;
            valid_q <= 1'b0;
            cfg_q   <= 1'b0;
        end else begin
            tw_q    <= clamped;
            valid_q <= route_change || (clamped != tw_q);
            cfg_q   <= stat.inverted;
        end
    end

    assign flag_set[FLG_LO] = stat.lo_hit;
    assign flag_set[FLG_HI] = stat.hi_hit;
    assign flag_clr[FLG_LO] = clr_lo;
    assign flag_clr[FLG_HI] = clr_hi;

    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
        tw_sticky_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (flag_set[gi]),
            .clr_i  (flag_clr[gi]),
            .flag_o (flag_q[gi])
        );
    end

    assign tw_out        = tw_q;
    assign tw_valid      = valid_q;
    assign cfg_err       = cfg_q;
    assign clamp_lo_flag = flag_q[FLG_LO];
    assign clamp_hi_flag = flag_q[FLG_HI];

    // ---------------- assertions ----------------
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_lo <= lim_hi) |=> (tw_out >= $past(lim_lo) && tw_out <= $past(lim_hi)));

    assert_inverted_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_lo > lim_hi) |=> (tw_out == $past(lim_lo) && cfg_err));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (route_sel == 2'b11 && tw_out >= lim_lo && tw_out <= lim_hi) |=> $stable(tw_out));

    assert_valid_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && tw_out != $past(tw_out)) |-> tw_valid);

    assert_route_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (route_sel != 2'b11 && route_in != state_q) |=> tw_valid);

endmodule

// File: tb/tw_route_clamp_tb.sv
module tw_route_clamp_tb_top;

    localparam int W = 48;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   route_sel = 2'b11;
    logic [W-1:0] free_word = '0;
    logic [W-1:0] loop_word = '0;
    logic         loop_strobe = 1'b0;
    logic [W-1:0] hist_word = '0;
    logic [W-1:0] lim_lo = '0;
    logic [W-1:0] lim_hi = '0;
    logic         clr_lo = 1'b0;
    logic         clr_hi = 1'b0;
    logic [W-1:0] tw_out;
    logic         tw_valid;
    logic         clamp_lo_flag;
    logic         clamp_hi_flag;
    logic         cfg_err;

    always #4 clk = ~clk;

    tw_route_clamp #(.TW_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .route_sel(route_sel),
        .free_word(free_word), .loop_word(loop_word), .loop_strobe(loop_strobe),
        .hist_word(hist_word), .lim_lo(lim_lo), .lim_hi(lim_hi),
        .clr_lo(clr_lo), .clr_hi(clr_hi), .tw_out(tw_out), .tw_valid(tw_valid),
        .clamp_lo_flag(clamp_lo_flag), .clamp_hi_flag(clamp_hi_flag), .cfg_err(cfg_err)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model state
    logic [W-1:0] m_out = '0;
    logic [1:0]   m_route = 2'b11;
    logic [W-1:0] m_loop = '0;
    logic         m_valid = 1'b0;
    logic         m_flo = 1'b0;
    logic         m_fhi = 1'b0;
    logic         m_cfg = 1'b0;

    function automatic logic [W-1:0] rnd48();
        logic [63:0] t;
        t = {$urandom(), $urandom()};
        return t[W-1:0];
    endfunction

    function automatic logic [W-1:0] ref_clamp(input logic [W-1:0] c,
                                               input logic [W-1:0] lo,
                                               input logic [W-1:0] hi);
        if (lo > hi) return lo;
        if (c < lo)  return lo;
        if (c > hi)  return hi;
        return c;
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // advance the model by one edge using the inputs now applied
    task automatic model_edge();
        logic [W-1:0] leff;
        logic [W-1:0] c;
        logic [W-1:0] cl;
        logic lo_hit;
        logic hi_hit;
        leff = loop_strobe ? loop_word : m_loop;
        if (loop_strobe) m_loop = loop_word;
        case (route_sel)
            2'b00:   c = free_word;
            2'b01:   c = leff;
            2'b10:   c = hist_word;
            default: c = m_out;
        endcase
        lo_hit  = (c < lim_lo);
        hi_hit  = !lo_hit && (c > lim_hi);
        cl      = ref_clamp(c, lim_lo, lim_hi);
        m_valid = (route_sel != m_route) || (cl != m_out);
        m_out   = cl;
        m_route = route_sel;
        m_flo   = (m_flo & ~clr_lo) | lo_hit;
        m_fhi   = (m_fhi & ~clr_hi) | hi_hit;
        m_cfg   = (lim_lo > lim_hi);
    endtask

    task automatic cycle(input string tag);
        model_edge();
        @(posedge clk);
        @(negedge clk);
        chk(tag, tw_out, m_out);
        chk("R8 tw_valid", {{(W-1){1'b0}}, tw_valid}, {{(W-1){1'b0}}, m_valid});
        chk("R6 low flag", {{(W-1){1'b0}}, clamp_lo_flag}, {{(W-1){1'b0}}, m_flo});
        chk("R7 high flag", {{(W-1){1'b0}}, clamp_hi_flag}, {{(W-1){1'b0}}, m_fhi});
        chk("R5 cfg_err", {{(W-1){1'b0}}, cfg_err}, {{(W-1){1'b0}}, m_cfg});
    endtask

    task automatic set_in(input logic [1:0] r, input logic [W-1:0] f,
                          input logic [W-1:0] l, input logic s, input logic [W-1:0] h);
        route_sel = r; free_word = f; loop_word = l; loop_strobe = s; hist_word = h;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset values before any active edge
        chk("R9 tw_out", tw_out, '0);
        chk("R9 flags", {{(W-4){1'b0}}, tw_valid, clamp_lo_flag, clamp_hi_flag, cfg_err}, '0);

        lim_lo = '0; lim_hi = '1;
        set_in(2'b00, 48'h1111_2222_3333, 48'hAAAA, 1'b0, 48'h5555);
        cycle("R1 free route");
        set_in(2'b01, 48'h1, 48'h0BAD_F00D_0001, 1'b1, 48'h5555);
        cycle("R1 loop route");
        set_in(2'b10, 48'h1, 48'h7, 1'b0, 48'h0000_C0FF_EE00);
        cycle("R1 history route");
        // R3: loop word moves without a strobe -> held value used
        set_in(2'b01, 48'h1, 48'h0123_4567_89AB, 1'b0, 48'h9);
        cycle("R3 held loop word");
        chk("R3 held value", tw_out, 48'h0BAD_F00D_0001);
        set_in(2'b01, 48'h1, 48'h0FFF_0000_0000, 1'b0, 48'h9);
        cycle("R3 ignored loop word");
        // R2: hold while other sources change
        set_in(2'b11, 48'h42, 48'h43, 1'b1, 48'h44);
        cycle("R2 hold");
        chk("R2 frozen", tw_out, 48'h0BAD_F00D_0001);
        cycle("R2 hold again");

        // R4 boundaries
        lim_lo = 48'd100; lim_hi = 48'd200;
        set_in(2'b00, 48'd100, 48'd0, 1'b0, 48'd0); cycle("R4 equal lower");
        chk("R4 equal lower value", tw_out, 48'd100);
        free_word = 48'd200; cycle("R4 equal upper");
        free_word = 48'd99;  cycle("R4 below lower");
        chk("R4 below value", tw_out, 48'd100);
        free_word = 48'd201; cycle("R4 above upper");
        free_word = 48'h8000_0000_0000; cycle("R4 unsigned top bit");
        chk("R4 unsigned value", tw_out, 48'd200);
        // R6/R7 clear behaviour
        free_word = 48'd150; clr_lo = 1'b1; clr_hi = 1'b1; cycle("R6 clear");
        clr_lo = 1'b0; clr_hi = 1'b0;
        free_word = 48'd50; cycle("R6 set low");
        free_word = 48'd40; clr_lo = 1'b1; cycle("R6 set wins over clear");
        clr_lo = 1'b0;
        // R5 inverted window
        lim_lo = 48'd300; lim_hi = 48'd200;
        free_word = 48'd250; cycle("R5 inverted mid");
        chk("R5 inverted value", tw_out, 48'd300);
        free_word = 48'd100; cycle("R5 inverted low");
        // R2 re-clamp on hold
        lim_lo = 48'd0; lim_hi = 48'd150;
        route_sel = 2'b11; cycle("R2 hold reclamp");
        chk("R2 reclamp value", tw_out, 48'd150);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            route_sel   = 2'($urandom_range(0, 3));
            loop_strobe = ($urandom_range(0, 9) < 3);
            if ($urandom_range(0, 3) != 0) free_word = rnd48();
            if ($urandom_range(0, 1) != 0) loop_word = rnd48();
            if ($urandom_range(0, 3) == 0) hist_word = rnd48();
            if ($urandom_range(0, 19) == 0) begin
                lim_lo = rnd48() >> 2;
                lim_hi = lim_lo + (rnd48() >> 1);
                if ($urandom_range(0, 9) == 0) lim_hi = lim_lo - 48'd1;
            end
            clr_lo = ($urandom_range(0, 9) == 0);
            clr_hi = ($urandom_range(0, 9) == 0);
            cycle("R1 random route");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule